// File: doc/BRIEF.md
# UART Buffer Mode Controller

This block is the buffer-control portion of a classic serial port. It owns a write-only control byte and the two data stores it governs: one for bytes waiting to be sent and one for bytes that have arrived. The stores run in one of two modes. In buffered mode each direction is a first-in first-out queue of up to 16 bytes. In legacy mode each direction is a single holding register.

Writing the control byte selects the mode, flushes either store on demand and sets the receive threshold. Any change of mode empties both stores. The serial shifter pushes received bytes and pops transmit bytes. The host side does the opposite. Occupancy counts, empty and full flags and a receive-threshold flag report the state of each store.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the block is in legacy mode (`fifo_mode_o`=0), both stores are empty (count 0, empty 1, full 0) and the receive threshold is 1 byte.
- R2: A control write with bit 0 set puts both directions into buffered mode together, and `fifo_mode_o` reads 1 from the next cycle on.
- R3: A control write with bit 0 clear selects legacy mode and empties both stores, even when the block is already in legacy mode.
- R4: A control write that changes the mode, in either direction, empties both stores in the same clock.
- R5: In a control write with bit 0 clear, bits 1, 2, 6 and 7 have no effect beyond what a write of 0x00 does, and the threshold field is not stored.
- R6: A control write with bits 0 and 2 set empties only the transmit store. The mode and the receive store are unchanged.
- R7: A control write with bits 0 and 1 set empties only the receive store. The mode and the transmit store are unchanged.
- R8: The flush bits act only in the write that carries them. A later write of 0x01 in buffered mode leaves both stores intact.
- R9: In buffered mode each store keeps up to 16 bytes in arrival order. A push into a full store is dropped, and a pop of an empty store changes nothing.
- R10: In legacy mode each store holds one byte. A push while a byte is held replaces it, and the count stays 1.
- R11: A push or pop in the same cycle as a flush of that store is dropped, and the store reads empty after that edge.
- R12: `rx_level_o` is 1 when the receive count is at or above the threshold in buffered mode, and when a byte is held in legacy mode. Control bits 7:6 select the threshold: 00=1, 01=4, 10=8, 11=14 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte value |
| tx_push_i | input | 1 | Host writes a byte to send |
| tx_data_i | input | 8 | Byte to send |
| tx_pop_i | input | 1 | Shifter takes the head byte |
| tx_data_o | output | 8 | Head of transmit store |
| tx_count_o | output | 5 | Transmit occupancy |
| tx_empty_o | output | 1 | Transmit store empty |
| tx_full_o | output | 1 | Transmit store full |
| rx_push_i | input | 1 | Shifter delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_pop_i | input | 1 | Host reads the head byte |
| rx_data_o | output | 8 | Head of receive store |
| rx_count_o | output | 5 | Receive occupancy |
| rx_empty_o | output | 1 | Receive store empty |
| rx_full_o | output | 1 | Receive store full |
| rx_level_o | output | 1 | Receive count at or above threshold |
| fifo_mode_o | output | 1 | 1 = buffered mode, 0 = legacy |

## Verification
Every push, pop and control write takes effect at the next rising edge. Counts, flags, mode and the head byte are therefore due one cycle after the stimulus, and the head byte is read straight from storage with no extra register. The bench drives inputs just after a falling edge and updates its reference queues at the rising edge. It compares every output at the following falling edge, so each result is read in the cycle it is due. Same-cycle flush and push or pop cases are run as single cycles, so the check shows whether the dropped access had any effect.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } rx_trig_e;

  function automatic int unsigned trig_bytes(rx_trig_e t);
    case (t)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/fifo_ctrl_reg.sv
module fifo_ctrl_reg
  import uart_fifo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic       fifo_mode_o,
  output rx_trig_e   trig_o,
  output logic       flush_tx_o,
  output logic       flush_rx_o
);
  logic     mode_q;
  rx_trig_e trig_q;
  logic     en_bit, mode_chg;

  assign en_bit   = wdata_i[0];
  assign mode_chg = we_i & (en_bit != mode_q);

  // bit0=0 always empties both; otherwise a mode change or a per-side reset bit
  assign flush_rx_o = (we_i & ~en_bit) | mode_chg | (we_i & en_bit & wdata_i[1]);
  assign flush_tx_o = (we_i & ~en_bit) | mode_chg | (we_i & en_bit & wdata_i[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      trig_q <= TRIG_1;
    end else if (we_i) begin
      mode_q <= en_bit;
      if (en_bit) trig_q <= rx_trig_e'(wdata_i[7:6]);
    end
  end

  assign fifo_mode_o = mode_q;
  assign trig_o      = trig_q;

  // R5
  disabled_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[0]) |=> (!fifo_mode_o && $stable(trig_o)));

  // R2
  enable_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[0]) |=> (fifo_mode_o && trig_o == rx_trig_e'($past(wdata_i[7:6]))));
endmodule

// File: rtl/byte_buffer.sv
module byte_buffer #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_mode_i,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [7:0]    data_i,
  input  logic          pop_i,
  output logic [7:0]    data_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] rptr_q, wptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (count_q == '0);
  assign full_o  = fifo_mode_i ? (count_q == FULL_CNT) : (count_q != '0);
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  // legacy mode always accepts: new byte replaces the held one
  assign do_push = push_i & ~flush_i & (~fifo_mode_i | ~full_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      count_q <= '0;
    end else if (fifo_mode_i) begin
      if (do_push) wptr_q <= ptr_inc(wptr_q);
      if (do_pop)  rptr_q <= ptr_inc(rptr_q);
      count_q <= count_q + CW'(do_push) - CW'(do_pop);
    end else begin
      if (do_push)     count_q <= CW'(1);
      else if (do_pop) count_q <= '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) begin
      if (fifo_mode_i) mem_q[wptr_q] <= data_i;
      else             mem_q[rptr_q] <= data_i;
    end
  end

  assign data_o  = mem_q[rptr_q];
  assign count_o = count_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);

  // R10
  legacy_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_mode_i |-> count_q <= CW'(1));

  // R11
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_q == '0);

  // R9
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && pop_i && !push_i && count_q == '0) |=> count_q == '0);

  // R9
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode_i && !flush_i && push_i && !pop_i && count_q == FULL_CNT) |=> count_q == FULL_CNT);
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [7:0]    cfg_wdata_i,
  input  logic          tx_push_i,
  input  logic [7:0]    tx_data_i,
  input  logic          tx_pop_i,
  output logic [7:0]    tx_data_o,
  output logic [CW-1:0] tx_count_o,
  output logic          tx_empty_o,
  output logic          tx_full_o,
  input  logic          rx_push_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_pop_i,
  output logic [7:0]    rx_data_o,
  output logic [CW-1:0] rx_count_o,
  output logic          rx_empty_o,
  output logic          rx_full_o,
  output logic          rx_level_o,
  output logic          fifo_mode_o
);
  rx_trig_e trig;
  logic     flush_tx, flush_rx;

  fifo_ctrl_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .fifo_mode_o(fifo_mode_o),
    .trig_o     (trig),
    .flush_tx_o (flush_tx),
    .flush_rx_o (flush_rx)
  );

  byte_buffer #(.DEPTH(DEPTH)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_mode_i(fifo_mode_o),
    .flush_i    (flush_tx),
    .push_i     (tx_push_i),
    .data_i     (tx_data_i),
    .pop_i      (tx_pop_i),
    .data_o     (tx_data_o),
    .count_o    (tx_count_o),
    .empty_o    (tx_empty_o),
    .full_o     (tx_full_o)
  );

  byte_buffer #(.DEPTH(DEPTH)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_mode_i(fifo_mode_o),
    .flush_i    (flush_rx),
    .push_i     (rx_push_i),
    .data_i     (rx_data_i),
    .pop_i      (rx_pop_i),
    .data_o     (rx_data_o),
    .count_o    (rx_count_o),
    .empty_o    (rx_empty_o),
    .full_o     (rx_full_o)
  );

  assign rx_level_o = fifo_mode_o ? (32'(rx_count_o) >= trig_bytes(trig)) : ~rx_empty_o;

  // R4
  mode_change_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode_o != $past(fifo_mode_o)) |-> (tx_empty_o && rx_empty_o));

  // R6
  tx_reset_keeps_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[2:0] == 3'b101 && fifo_mode_o && !rx_push_i && !rx_pop_i)
    |=> (fifo_mode_o && $stable(rx_count_o) && tx_empty_o));

  // R12
  level_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> !rx_level_o);
endmodule

// File: tb/tb_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cfg_we = 0, tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] cfg_wdata = 0, tx_din = 0, rx_din = 0;
  logic [7:0] tx_dout, rx_dout;
  logic [4:0] tx_cnt, rx_cnt;
  logic       tx_empty, tx_full, rx_empty, rx_full, rx_level, fmode;

  uart_fifo_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop), .tx_data_o(tx_dout),
    .tx_count_o(tx_cnt), .tx_empty_o(tx_empty), .tx_full_o(tx_full),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_pop_i(rx_pop), .rx_data_o(rx_dout),
    .rx_count_o(rx_cnt), .rx_empty_o(rx_empty), .rx_full_o(rx_full),
    .rx_level_o(rx_level), .fifo_mode_o(fmode)
  );

  int checks = 0, errors = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit         mode_m = 0;
  logic [1:0] trig_m = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int thr(logic [1:0] t);
    case (t) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  task automatic upd(ref logic [7:0] q[$], input bit fl, input bit md,
                     input bit ps, input logic [7:0] d, input bit pp);
    bit acc;
    if (fl) begin q.delete(); return; end
    if (md) begin
      acc = ps && q.size() < 16;
      if (pp && q.size() > 0) void'(q.pop_front());
      if (acc) q.push_back(d);
    end else begin
      if (pp && q.size() > 0) void'(q.pop_front());
      if (ps) begin q.delete(); q.push_back(d); end
    end
  endtask

  // monitor: compare every output against the reference queues
  task automatic compare(string tag);
    int lvl;
    chk(tag, "mode", int'(fmode), int'(mode_m));
    chk(tag, "tx_count", int'(tx_cnt), txq.size());
    chk(tag, "rx_count", int'(rx_cnt), rxq.size());
    chk(tag, "tx_empty", int'(tx_empty), int'(txq.size() == 0));
    chk(tag, "rx_empty", int'(rx_empty), int'(rxq.size() == 0));
    chk(tag, "tx_full", int'(tx_full), int'(mode_m ? txq.size() == 16 : txq.size() == 1));
    chk(tag, "rx_full", int'(rx_full), int'(mode_m ? rxq.size() == 16 : rxq.size() == 1));
    if (txq.size() > 0) chk(tag, "tx_head", int'(tx_dout), int'(txq[0]));
    if (rxq.size() > 0) chk(tag, "rx_head", int'(rx_dout), int'(rxq[0]));
    lvl = mode_m ? int'(rxq.size() >= thr(trig_m)) : int'(rxq.size() > 0);
    chk(tag, "rx_level", int'(rx_level), lvl);
  endtask

  // driver: one clock of stimulus, reference update at the edge, compare after
  task automatic cyc(string tag, bit we, logic [7:0] wd, bit tps, logic [7:0] td, bit tpp,
                     bit rps, logic [7:0] rd, bit rpp);
    bit ftx, frx;
    cfg_we = we; cfg_wdata = wd; tx_push = tps; tx_din = td; tx_pop = tpp;
    rx_push = rps; rx_din = rd; rx_pop = rpp;
    @(posedge clk);
    ftx = we && (!wd[0] || wd[2] || (wd[0] != mode_m));
    frx = we && (!wd[0] || wd[1] || (wd[0] != mode_m));
    upd(txq, ftx, mode_m, tps, td, tpp);
    upd(rxq, frx, mode_m, rps, rd, rpp);
    if (we) begin mode_m = wd[0]; if (wd[0]) trig_m = wd[7:6]; end
    @(negedge clk);
    cfg_we = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    compare(tag);
  endtask

  task automatic wr(string tag, logic [7:0] v);       cyc(tag, 1, v, 0, 0, 0, 0, 0, 0); endtask
  task automatic tpush(string tag, logic [7:0] d);    cyc(tag, 0, 0, 1, d, 0, 0, 0, 0); endtask
  task automatic tpop(string tag);                    cyc(tag, 0, 0, 0, 0, 1, 0, 0, 0); endtask
  task automatic rpush(string tag, logic [7:0] d);    cyc(tag, 0, 0, 0, 0, 0, 1, d, 0); endtask
  task automatic rpop(string tag);                    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // legacy single byte, overwrite
    tpush("R10", 8'h11);
    tpush("R10", 8'h22);
    rpush("R10", 8'h33);
    rpush("R10", 8'h44);
    tpop("R10");
    rpop("R9");                       // now empty in legacy
    rpop("R9");                       // pop of empty
    wr("R3", 8'h00);                  // already legacy: nothing held, still legacy

    // mode change flushes held bytes
    rpush("R4", 8'h55);
    tpush("R4", 8'h66);
    wr("R2", 8'h01);                  // to buffered: both flushed
    wr("R8", 8'h01);                  // no flush bits
    for (int i = 0; i < 17; i++) tpush("R9", 8'(8'hA0 + i));
    wr("R8", 8'h01);                  // full store survives
    for (int i = 0; i < 3; i++) tpop("R9");
    cyc("R9", 0, 0, 1, 8'hEE, 1, 0, 0, 0);  // push and pop together

    // threshold
    wr("R12", 8'h41);                 // thr 4
    for (int i = 0; i < 5; i++) rpush("R12", 8'(8'h10 + i));
    wr("R12", 8'hC1);                 // thr 14, keeps data
    for (int i = 0; i < 10; i++) rpush("R12", 8'(8'h20 + i));
    wr("R12", 8'h81);                 // thr 8
    for (int i = 0; i < 8; i++) rpop("R12");

    // selective flushes
    wr("R6", 8'h05);
    for (int i = 0; i < 4; i++) tpush("R7", 8'(8'h70 + i));
    wr("R7", 8'h03);
    rpush("R11", 8'h01);
    cyc("R11", 1, 8'h03, 1, 8'h99, 0, 1, 8'h77, 0);   // rx push dropped, tx push kept
    cyc("R11", 1, 8'h05, 0, 0, 1, 0, 0, 1);           // tx pop dropped with flush
    tpush("R11", 8'h5A);
    rpush("R11", 8'hA5);

    // disabled write: only bit0 matters
    wr("R5", 8'hC6);
    rpush("R5", 8'h12);
    tpush("R5", 8'h34);
    wr("R3", 8'h00);                  // legacy to legacy still empties
    rpush("R5", 8'h56);
    wr("R4", 8'h01);                  // trig goes to 1 via enabled write
    rpush("R12", 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule